// File: doc/BRIEF.md
# Software Interrupt Fan-out Walker

This block takes a 64-bit software-interrupt request from one core and delivers it to the cores it selects. It then steps through a configured set of cores, one core per clock and in ascending index order. Each core has a 24-bit affinity value (level 2 in bits 23:16, level 1 in bits 15:8, level 0 in bits 7:0). For every core that is selected and allowed to take the interrupt, the block drives a one-cycle set-pending strobe that carries the core index and the interrupt ID. Pending-state storage and prioritisation sit in the consumer of that strobe.

Each request selects its cores in one of two ways. In the targeted way, a core is selected when its upper affinity levels equal the request's values and the request's 16-bit target list has the bit at its level-0 value set. In the broadcast way, every core except the requester is selected. In targeted mode the block clears each selected core's bit from a working copy of the target list, and the walk stops as soon as that copy is empty. Delivery is gated per core by an interrupt-group bit. The block fetches that bit through a combinational lookup port that is addressed by the core and interrupt ID currently being visited. A busy flag and a one-cycle done pulse mark the start and end of each request.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset `busy`, `done` and `pend_valid` are all low.
- R2: A request is taken on a clock edge where `req_valid` is high and `busy` is low, and `busy` is high from the next cycle on. A `req_valid` pulse seen while `busy` is high has no effect on the strobes, the visit count or the number of done pulses.
- R3: Request word fields: target list in bits 15:0, level-1 affinity in 23:16, interrupt ID in 27:24, level-2 affinity in 39:32, broadcast bit in 40, and level-3 affinity in 55:48. All other bits are ignored.
- R4: With the broadcast bit clear, a core is selected only when the request's level-3 value is zero, its level-2 and level-1 values equal the core's, the core's level-0 value is below 16, and the target-list bit indexed by that level-0 value is set.
- R5: With the broadcast bit set, every core except the one at index `req_src` is selected.
- R6: A selected core gets a strobe only if `lk_is_g1` is 0 for it or `req_g1_ok` was high when the request was taken. Otherwise the core is skipped and no strobe is sent.
- R7: One core is visited per busy cycle, starting at index 0 and ascending. `lk_core` and `pend_core` give the visited index.
- R8: In targeted mode the selected core's bit is cleared from the working list, and the walk ends on the visit that leaves the list empty. If the list is empty from the start, only core 0 is visited. In broadcast mode all `NCORES` cores are visited.
- R9: `done` is high for exactly one cycle, the cycle after the last visit, and `busy` is low in that cycle.
- R10: Every strobe carries the interrupt ID of the request being walked on `pend_intid`, and `lk_intid` shows the same ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_word | input | 64 | Request word (fields in R3) |
| req_src | input | CW | Index of the requesting core |
| req_g1_ok | input | 1 | Group-1 interrupts may be delivered |
| core_aff | input | NCORES*24 | Affinity of each core, core 0 in the lowest 24 bits |
| lk_core | output | CW | Group lookup: core being visited |
| lk_intid | output | 4 | Group lookup: interrupt ID |
| lk_is_g1 | input | 1 | Group lookup result, 1 = group 1 |
| pend_valid | output | 1 | Set-pending strobe |
| pend_core | output | CW | Core that receives the strobe |
| pend_intid | output | 4 | Interrupt ID to set pending |
| busy | output | 1 | A request is being walked |
| done | output | 1 | One-cycle pulse when a walk ends |

## Verification
The targeted sweep covers 64 target-list patterns, built from the bits that hit configured level-0 values and bits that hit none. These are crossed with matching and non-matching level-1, level-2 and level-3 values and with both settings of the group-1 flag. The sweep therefore separates a correct affinity compare from a wrong or missing one. It separates proper bit clearing from missing clearing through the visit count at early exit. It also separates group gating from ungated delivery. Broadcast requests from every source index show that the requester alone is skipped and that the walk never ends early. A request offered mid-walk shows that it is refused.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int AFFW = 24;
    localparam int IDW  = 4;
    localparam int TLW  = 16;
    localparam int SELW = $clog2(TLW);

    typedef struct packed {
        logic [TLW-1:0] tlist;
        logic [7:0]     aff1;
        logic [7:0]     aff2;
        logic [7:0]     aff3;
        logic [IDW-1:0] intid;
        logic           bcast;
    } sgi_req_t;
endpackage

// File: rtl/sgi_req_unpack.sv
module sgi_req_unpack
    import sgi_pkg::*;
(
    input  logic [63:0] word,
    output sgi_req_t    req
);
    always_comb begin
        req.tlist = word[15:0];
        req.aff1  = word[23:16];
        req.intid = word[27:24];
        req.aff2  = word[39:32];
        req.bcast = word[40];
        req.aff3  = word[55:48];
    end
endmodule

// File: rtl/sgi_aff_mux.sv
module sgi_aff_mux
    import sgi_pkg::*;
#(
    parameter int NCORES = 8,
    parameter int CW     = 3
) (
    input  logic [NCORES*AFFW-1:0] flat,
    input  logic [CW-1:0]          sel,
    output logic [AFFW-1:0]        aff
);
    logic [AFFW-1:0] tbl [NCORES];

    for (genvar g = 0; g < NCORES; g++) begin : g_unpack
        assign tbl[g] = flat[g*AFFW +: AFFW];
    end

    always_comb begin
        aff = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (sel == CW'(i)) aff = tbl[i];
        end
    end
endmodule

// File: rtl/sgi_core_match.sv
module sgi_core_match
    import sgi_pkg::*;
#(
    parameter int CW = 3
) (
    input  sgi_req_t        req,
    input  logic [AFFW-1:0] aff,
    input  logic [CW-1:0]   core,
    input  logic [CW-1:0]   src,
    output logic            hit,
    output logic [TLW-1:0]  clr
);
    logic [SELW-1:0] lvl0;
    logic            tgt;

    always_comb begin
        lvl0 = aff[SELW-1:0];
        tgt  = (req.aff3 == 8'd0)
            && (req.aff2 == aff[23:16])
            && (req.aff1 == aff[15:8])
            && (aff[7:SELW] == '0)
            && req.tlist[lvl0];
        hit  = req.bcast ? (core != src) : tgt;
        clr  = '0;
        if (!req.bcast && tgt) clr[lvl0] = 1'b1;
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter  int NCORES = 8,
    localparam int CW     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [63:0]            req_word,
    input  logic [CW-1:0]          req_src,
    input  logic                   req_g1_ok,
    input  logic [NCORES*AFFW-1:0] core_aff,
    output logic [CW-1:0]          lk_core,
    output logic [IDW-1:0]         lk_intid,
    input  logic                   lk_is_g1,
    output logic                   pend_valid,
    output logic [CW-1:0]          pend_core,
    output logic [IDW-1:0]         pend_intid,
    output logic                   busy,
    output logic                   done
);
    localparam logic [CW-1:0] LAST_IDX = CW'(NCORES - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          g1ok;
        logic [CW-1:0] src;
        logic [CW-1:0] idx;
        sgi_req_t      req;
    } st_t;

    st_t st_d, st_q;

    sgi_req_t        in_req;
    logic [AFFW-1:0] cur_aff;
    logic            hit;
    logic [TLW-1:0]  clr;
    logic [TLW-1:0]  rem;
    logic            fire;

    sgi_req_unpack u_unpack (
        .word (req_word),
        .req  (in_req)
    );

    sgi_aff_mux #(.NCORES(NCORES), .CW(CW)) u_mux (
        .flat (core_aff),
        .sel  (st_q.idx),
        .aff  (cur_aff)
    );

    sgi_core_match #(.CW(CW)) u_match (
        .req  (st_q.req),
        .aff  (cur_aff),
        .core (st_q.idx),
        .src  (st_q.src),
        .hit  (hit),
        .clr  (clr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rem       = st_q.req.tlist & ~clr;
        fire      = st_q.busy && hit && (!lk_is_g1 || st_q.g1ok);
        if (st_q.busy) begin
            st_d.req.tlist = rem;
            if (st_q.idx == LAST_IDX || (!st_q.req.bcast && rem == '0)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (req_valid) begin
            st_d.busy = 1'b1;
            st_d.req  = in_req;
            st_d.g1ok = req_g1_ok;
            st_d.src  = req_src;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_core    = st_q.idx;
    assign lk_intid   = st_q.req.intid;
    assign pend_valid = fire;
    assign pend_core  = st_q.idx;
    assign pend_intid = st_q.req.intid;
    assign busy       = st_q.busy;
    assign done       = st_q.done;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter  int NCORES = 8,
    localparam int CW     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [63:0]    req_word,
    input logic           req_g1_ok,
    input logic           busy,
    input logic           done,
    input logic           pend_valid,
    input logic [IDW-1:0] pend_intid,
    input logic [CW-1:0]  lk_core,
    input logic           lk_is_g1
);
    logic           g1_cap;
    logic [IDW-1:0] id_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g1_cap <= 1'b0;
            id_cap <= '0;
        end else if (req_valid && !busy) begin
            g1_cap <= req_g1_ok;
            id_cap <= req_word[27:24];
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
    AST_STROBE_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n) pend_valid |-> busy); // R7
    AST_WALK_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> lk_core == '0); // R7
    AST_WALK_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> lk_core == $past(lk_core) + 1'b1); // R7
    AST_GROUP_GATE: assert property (@(posedge clk) disable iff (!rst_n) (pend_valid && lk_is_g1) |-> g1_cap); // R6
    AST_STROBE_ID: assert property (@(posedge clk) disable iff (!rst_n) pend_valid |-> pend_intid == id_cap); // R10
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCORES(NCORES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_word   (req_word),
    .req_g1_ok  (req_g1_ok),
    .busy       (busy),
    .done       (done),
    .pend_valid (pend_valid),
    .pend_intid (pend_intid),
    .lk_core    (lk_core),
    .lk_is_g1   (lk_is_g1)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
    localparam int N  = 6;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [63:0]   req_word = '0;
    logic [CW-1:0] req_src = '0;
    logic          req_g1_ok = 1'b0;
    logic [N*24-1:0] core_aff;
    logic [CW-1:0] lk_core;
    logic [3:0]    lk_intid;
    logic          lk_is_g1;
    logic          pend_valid;
    logic [CW-1:0] pend_core;
    logic [3:0]    pend_intid;
    logic          busy;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // core: {aff2, aff1, aff0}
    assign core_aff = {24'h00_01_14, 24'h00_01_0F, 24'h00_02_02,
                       24'h00_01_05, 24'h00_01_00, 24'h00_01_02};

    function automatic logic grp_of(int c, int id);
        return 1'(((c * 7 + id * 3) >> 1) & 1);
    endfunction

    assign lk_is_g1 = grp_of(int'(lk_core), int'(lk_intid));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    sgi_dispatch #(.NCORES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_src(req_src), .req_g1_ok(req_g1_ok), .core_aff(core_aff),
        .lk_core(lk_core), .lk_intid(lk_intid), .lk_is_g1(lk_is_g1),
        .pend_valid(pend_valid), .pend_core(pend_core), .pend_intid(pend_intid),
        .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_word(int tl, int a1, int id, int a2, int bc, int a3);
        logic [63:0] w;
        w = 64'hA5C0_7E00_F0F0_0000;  // junk in unused bits (R3)
        w[15:0]  = 16'(tl);
        w[23:16] = 8'(a1);
        w[27:24] = 4'(id);
        w[39:32] = 8'(a2);
        w[40]    = 1'(bc);
        w[55:48] = 8'(a3);
        return w;
    endfunction

    // runs one request and compares strobes and visit count against the model
    task automatic run_req(input int tl, input int a1, input int id, input int a2,
                           input int bc, input int a3, input int src, input int g1,
                           input logic poke);
        int exp_core[N];
        int exp_n = 0, exp_vis = 0;
        int got_core[N];
        int got_n = 0, got_vis = 0, bad_id = 0, guard = 0;
        logic [15:0] m = 16'(tl);
        logic ok;
        for (int c = 0; c < N; c++) begin
            logic [23:0] a = core_aff[c*24 +: 24];
            logic h;
            if (bc != 0) h = (c != src);
            else h = (a3 == 0) && (int'(a[23:16]) == a2) && (int'(a[15:8]) == a1)
                     && (a[7:0] < 16) && m[a[3:0]];
            if (h && bc == 0) m[a[3:0]] = 1'b0;
            if (h && (!grp_of(c, id) || g1 != 0)) begin
                exp_core[exp_n] = c;
                exp_n++;
            end
            exp_vis = c + 1;
            if (bc == 0 && m == 0) break;
        end
        @(negedge clk);
        req_word = mk_word(tl, a1, id, a2, bc, a3);
        req_src = CW'(src);
        req_g1_ok = 1'(g1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 40) begin
            if (busy) got_vis++;
            if (pend_valid) begin
                if (got_n < N) got_core[got_n] = int'(pend_core);
                got_n++;
                if (int'(pend_intid) != id) bad_id++;
            end
            if (poke && got_vis == 2) begin
                req_word = mk_word(16'hFFFF, 1, (id + 1) % 16, 0, 1, 0);
                req_src = '0;
                req_g1_ok = 1'b1;
                req_valid = 1'b1;
            end else req_valid = 1'b0;
            guard++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        ok = (got_n == exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++)
            if (got_core[k] != exp_core[k]) ok = 1'b0;
        chk(ok, bc != 0 ? "R5/R6/R7 broadcast strobe list (count)" :
                           "R3/R4/R6/R7 targeted strobe list (count)", got_n, exp_n);
        chk(got_vis == exp_vis, "R8 visits before done", got_vis, exp_vis);
        chk(bad_id == 0, "R10 strobe interrupt ID errors", bad_id, 0);
        chk(done && !busy, "R9 done with busy low", int'({done, busy}), 2);
        @(negedge clk);
        chk(!done, "R9 done lasts one cycle", int'(done), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(!busy && !done, "R2 request during walk refused", int'({busy, done}), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pend_valid, "R1 reset state",
            int'({busy, done, pend_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R2 idle without request", int'(busy), 0);
        // targeted sweep
        for (int mi = 0; mi < 64; mi++) begin
            int tl = (((mi >> 5) & 1) << 15) | (((mi >> 4) & 1) << 5) | (mi & 15);
            for (int a1 = 1; a1 <= 3; a1++)
                for (int ax = 0; ax < 3; ax++)
                    for (int g1 = 0; g1 < 2; g1++)
                        run_req(tl, a1, (mi ^ a1) & 15, ax == 1 ? 1 : 0, 0,
                                ax == 2 ? 1 : 0, mi % N, g1, 1'b0);
        end
        // empty list and all-ones list
        run_req(0, 1, 3, 0, 0, 0, 0, 1, 1'b0);
        run_req(16'hFFFF, 1, 9, 0, 0, 0, 2, 1, 1'b0);
        // broadcast sweep
        for (int s = 0; s < N; s++)
            for (int g1 = 0; g1 < 2; g1++)
                for (int id = 0; id < 16; id++)
                    run_req(id * 4369, 7, id, 3, 1, 2, s, g1, 1'b0);
        // refused request during walk
        run_req(16'h8025, 1, 5, 0, 0, 0, 1, 0, 1'b1);
        run_req(0, 0, 12, 0, 1, 0, 4, 1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule